// File: doc/BRIEF.md
# SMI Command and Feature-Negotiation Port

This block implements two byte-wide I/O registers used by firmware to enter system management mode. A write to the command register raises a system management interrupt (SMI). The SMI goes to one CPU or to every CPU, depending on which optional behaviours have been negotiated. The status register works as a small handshake. Bit 1 of a written byte picks the operation: a query of what the platform offers, or a request to turn on a chosen subset of features. Bits 2 to 7 carry the feature bits, and a read of the register reports the outcome. Bit 0 is a plain stored bit that older firmware uses as a scratch flag.

On a query, bit 1 reads back as 0 when the negotiation logic is present, and bits 2 to 7 show the available features. On a set, bit 1 reads back as 1 when the request named something unavailable, and bits 2 to 7 read back as zero. Broadcast SMI sits at status bit 2 and is the only feature defined so far. The I/O interface is synchronous. Reads are combinational while the read strobe is high. Each SMI output is a one-cycle pulse, registered after the command write.

Top module: `smi_feature_port`

## Requirements
- R1: After reset, both registers read 0x00 and no SMI output is asserted.
- R2: Status bit 0 reads back exactly the value last written to it, whatever the other bits carry.
- R3: A status write with bit 1 = 1 (query) makes the register read {available features in bits 7:2, 0 in bit 1, written bit 0}; with the default configuration the available set is only bit 2 (broadcast SMI), so the read value is 0x04 | bit 0.
- R4: A status write with bit 1 = 0 (set) whose bits 7:2 request only available features reads back as 0 in bits 7:1 and enables exactly the requested set.
- R5: A set request naming any unavailable feature bit (default: any of bits 7:3) reads back with bit 1 = 1 and bits 7:2 = 0, and leaves the enabled feature set unchanged.
- R6: Writing 0x00 or 0x01 to the status register always succeeds: it reads back as written and disables every feature, so the SMI goes back to the writing CPU only.
- R7: The command register (address 0xB2) reads back the last byte written to it; the status register is at address 0xB3.
- R8: With broadcast disabled, a command write asserts only SMI output number cpu_idx, in the cycle after the write.
- R9: With broadcast enabled, a command write asserts every SMI output in the cycle after the write.
- R10: Each SMI output is high for exactly one cycle per command write, and is low in any cycle that does not follow a command write.
- R11: Writes to any address other than 0xB2 and 0xB3 change neither register and raise no SMI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | Write strobe, one byte per cycle |
| io_rd | input | 1 | Read strobe; io_rdata is valid while it is high |
| io_addr | input | ADDR_W | I/O address |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, zero when not reading a mapped register |
| cpu_idx | input | CPU_W | Index of the CPU performing the access |
| smi_pulse | output | NUM_CPU | One SMI pulse line per CPU |

## Verification
The assertions assume that io_wr is never high in two back-to-back cycles with different CPUs targeted, which the bench satisfies by writing once every two cycles. They also assume that cpu_idx always names an existing CPU. The bench drives only indices below NUM_CPU, and it rotates the index across all CPUs. The status sweep covers all 256 byte values. Each value is followed by a command write, so the enabled feature set is checked through the SMI pattern it produces.

// File: rtl/smi_port_pkg.sv
package smi_port_pkg;

   typedef logic [7:0] io_byte_t;

   localparam int unsigned STS_KEEP_BIT = 0;
   localparam int unsigned STS_OP_BIT   = 1;
   localparam int unsigned FEAT_LSB     = 2;
   localparam int unsigned FEAT_W       = 6;
   localparam int unsigned FEAT_BCAST   = 0;

   typedef logic [FEAT_W-1:0] feat_vec_t;

   typedef enum logic {
      NEG_SET   = 1'b0,
      NEG_QUERY = 1'b1
   } neg_op_e;

   function automatic neg_op_e op_of(input io_byte_t b);
      return neg_op_e'(b[STS_OP_BIT]);
   endfunction

   function automatic feat_vec_t feat_of(input io_byte_t b);
      return b[FEAT_LSB +: FEAT_W];
   endfunction

   function automatic io_byte_t pack_sts(input feat_vec_t f, input logic err, input logic keep);
      return {f, err, keep};
   endfunction

endpackage

// File: rtl/smi_io_decode.sv
module smi_io_decode #(
   parameter int unsigned ADDR_W   = 16,
   parameter logic [ADDR_W-1:0] CMD_ADDR = 'hB2,
   parameter logic [ADDR_W-1:0] STS_ADDR = 'hB3
) (
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [ADDR_W-1:0] io_addr,
   output logic              wr_cmd,
   output logic              wr_sts,
   output logic              rd_cmd,
   output logic              rd_sts
);
   logic hit_cmd, hit_sts;

   always_comb begin
      hit_cmd = (io_addr == CMD_ADDR);
      hit_sts = (io_addr == STS_ADDR);
      wr_cmd  = io_wr & hit_cmd;
      wr_sts  = io_wr & hit_sts;
      rd_cmd  = io_rd & hit_cmd;
      rd_sts  = io_rd & hit_sts;
   end
endmodule

// File: rtl/smi_cmd_reg.sv
module smi_cmd_reg
   import smi_port_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     wr_cmd,
   input  io_byte_t wdata,
   output io_byte_t cmd_q,
   output logic     fire_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q  <= '0;
         fire_q <= 1'b0;
      end else begin
         fire_q <= wr_cmd;
         if (wr_cmd) cmd_q <= wdata;
      end
   end
endmodule

// File: rtl/smi_negotiator.sv
module smi_negotiator
   import smi_port_pkg::*;
#(
   parameter feat_vec_t FEAT_AVAIL      = 6'b000001,
   parameter bit        HAS_NEGOTIATION = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wr_sts,
   input  io_byte_t  wdata,
   output io_byte_t  sts_q,
   output feat_vec_t feat_en
);
   io_byte_t  sts_d;
   feat_vec_t en_d;
   feat_vec_t req;
   logic      bad;

   generate
      if (HAS_NEGOTIATION) begin : g_neg
         always_comb begin
            req   = feat_of(wdata);
            bad   = |(req & ~FEAT_AVAIL);
            sts_d = sts_q;
            en_d  = feat_en;
            if (wr_sts) begin
               if (op_of(wdata) == NEG_QUERY) begin
                  sts_d = pack_sts(FEAT_AVAIL, 1'b0, wdata[STS_KEEP_BIT]);
               end else begin
                  sts_d = pack_sts('0, bad, wdata[STS_KEEP_BIT]);
                  if (!bad) en_d = req;
               end
            end
         end
      end else begin : g_legacy
         always_comb begin
            req   = feat_of(wdata);
            bad   = |req;
            sts_d = sts_q;
            en_d  = '0;
            if (wr_sts) begin
               if (op_of(wdata) == NEG_QUERY)
                  sts_d = pack_sts('0, 1'b1, wdata[STS_KEEP_BIT]);
               else
                  sts_d = pack_sts('0, bad, wdata[STS_KEEP_BIT]);
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sts_q   <= '0;
         feat_en <= '0;
      end else begin
         sts_q   <= sts_d;
         feat_en <= en_d;
      end
   end
endmodule

// File: rtl/smi_pulse_gen.sv
module smi_pulse_gen #(
   parameter int unsigned NUM_CPU = 4,
   parameter int unsigned CPU_W   = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_cmd,
   input  logic               bcast,
   input  logic [CPU_W-1:0]   cpu_idx,
   output logic [NUM_CPU-1:0] smi_q
);
   generate
      for (genvar i = 0; i < NUM_CPU; i++) begin : g_lane
         logic hit;
         always_comb hit = wr_cmd & (bcast | (cpu_idx == CPU_W'(i)));
         always_ff @(posedge clk) begin
            if (!rst_n) smi_q[i] <= 1'b0;
            else        smi_q[i] <= hit;
         end
      end
   endgenerate
endmodule

// File: rtl/smi_feature_port.sv
module smi_feature_port
   import smi_port_pkg::*;
#(
   parameter int unsigned       ADDR_W          = 16,
   parameter logic [ADDR_W-1:0] CMD_ADDR        = 'hB2,
   parameter logic [ADDR_W-1:0] STS_ADDR        = 'hB3,
   parameter int unsigned       NUM_CPU         = 4,
   parameter int unsigned       CPU_W           = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
   parameter logic [5:0]        FEAT_AVAIL      = 6'b000001,
   parameter bit                HAS_NEGOTIATION = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               io_wr,
   input  logic               io_rd,
   input  logic [ADDR_W-1:0]  io_addr,
   input  logic [7:0]         io_wdata,
   output logic [7:0]         io_rdata,
   input  logic [CPU_W-1:0]   cpu_idx,
   output logic [NUM_CPU-1:0] smi_pulse
);
   localparam int unsigned MIN_CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;

   generate
      if (NUM_CPU < 1) begin : g_bad_cpu
         $error("NUM_CPU must be at least 1");
      end
      if (CPU_W < MIN_CPU_W) begin : g_bad_w
         $error("CPU_W too narrow for NUM_CPU");
      end
      if (CMD_ADDR == STS_ADDR) begin : g_bad_addr
         $error("command and status addresses must differ");
      end
   endgenerate

   logic      wr_cmd, wr_sts, rd_cmd, rd_sts;
   io_byte_t  cmd_q, sts_q;
   feat_vec_t feat_en;
   logic      fire_q;

   smi_io_decode #(
      .ADDR_W  (ADDR_W),
      .CMD_ADDR(CMD_ADDR),
      .STS_ADDR(STS_ADDR)
   ) u_dec (
      .io_wr  (io_wr),
      .io_rd  (io_rd),
      .io_addr(io_addr),
      .wr_cmd (wr_cmd),
      .wr_sts (wr_sts),
      .rd_cmd (rd_cmd),
      .rd_sts (rd_sts)
   );

   smi_cmd_reg u_cmd (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_cmd(wr_cmd),
      .wdata (io_wdata),
      .cmd_q (cmd_q),
      .fire_q(fire_q)
   );

   smi_negotiator #(
      .FEAT_AVAIL     (FEAT_AVAIL),
      .HAS_NEGOTIATION(HAS_NEGOTIATION)
   ) u_neg (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_sts (wr_sts),
      .wdata  (io_wdata),
      .sts_q  (sts_q),
      .feat_en(feat_en)
   );

   smi_pulse_gen #(
      .NUM_CPU(NUM_CPU),
      .CPU_W  (CPU_W)
   ) u_pulse (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_cmd (wr_cmd),
      .bcast  (feat_en[FEAT_BCAST]),
      .cpu_idx(cpu_idx),
      .smi_q  (smi_pulse)
   );

   always_comb begin
      io_rdata = '0;
      if (rd_cmd) io_rdata = cmd_q;
      if (rd_sts) io_rdata = sts_q;
   end
endmodule

// File: rtl/smi_feature_port_chk.sv
module smi_feature_port_chk #(
   parameter int unsigned       ADDR_W     = 16,
   parameter logic [ADDR_W-1:0] CMD_ADDR   = 'hB2,
   parameter logic [ADDR_W-1:0] STS_ADDR   = 'hB3,
   parameter int unsigned       NUM_CPU    = 4,
   parameter int unsigned       CPU_W      = 2,
   parameter logic [5:0]        FEAT_AVAIL = 6'b000001
) (
   input logic               clk,
   input logic               rst_n,
   input logic               io_wr,
   input logic [ADDR_W-1:0]  io_addr,
   input logic [7:0]         io_wdata,
   input logic [CPU_W-1:0]   cpu_idx,
   input logic [NUM_CPU-1:0] smi_pulse,
   input logic [7:0]         sts_q,
   input logic [7:0]         cmd_q,
   input logic [5:0]         feat_en
);
   logic w_cmd, w_sts, w_other;
   always_comb begin
      w_cmd   = io_wr && (io_addr == CMD_ADDR);
      w_sts   = io_wr && (io_addr == STS_ADDR);
      w_other = io_wr && (io_addr != CMD_ADDR) && (io_addr != STS_ADDR);
   end

   // R1
   reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> (smi_pulse == '0) && (sts_q == 8'h00));

   // R2
   keep_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      w_sts |=> sts_q[0] == $past(io_wdata[0]));

   // R5
   bad_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (w_sts && !io_wdata[1] && ((io_wdata[7:2] & ~FEAT_AVAIL) != 6'd0))
      |=> sts_q[1] && $stable(feat_en) && (sts_q[7:2] == 6'd0));

   // R8
   single_smi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (w_cmd && !feat_en[0] && (int'(cpu_idx) < NUM_CPU))
      |=> ($countones(smi_pulse) == 1) && smi_pulse[$past(cpu_idx)]);

   // R9
   bcast_smi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (w_cmd && feat_en[0]) |=> &smi_pulse);

   // R10
   no_stray_smi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !w_cmd |=> (smi_pulse == '0));

   // R11
   other_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      w_other |=> $stable(sts_q) && $stable(cmd_q));

   // R7
   cmd_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      w_cmd |=> cmd_q == $past(io_wdata));
endmodule

bind smi_feature_port smi_feature_port_chk #(
   .ADDR_W    (ADDR_W),
   .CMD_ADDR  (CMD_ADDR),
   .STS_ADDR  (STS_ADDR),
   .NUM_CPU   (NUM_CPU),
   .CPU_W     (CPU_W),
   .FEAT_AVAIL(FEAT_AVAIL)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .io_wr    (io_wr),
   .io_addr  (io_addr),
   .io_wdata (io_wdata),
   .cpu_idx  (cpu_idx),
   .smi_pulse(smi_pulse),
   .sts_q    (sts_q),
   .cmd_q    (cmd_q),
   .feat_en  (feat_en)
);

// File: tb/smi_feature_port_tb.sv
`timescale 1ns/1ps
module smi_feature_port_tb;
   localparam int NCPU = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        io_wr = 1'b0;
   logic        io_rd = 1'b0;
   logic [15:0] io_addr = '0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata;
   logic [1:0]  cpu_idx = '0;
   logic [3:0]  smi_pulse;

   int checks = 0;
   int fails  = 0;
   bit bcast_m = 1'b0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   smi_feature_port u_dut (
      .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
      .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
      .cpu_idx(cpu_idx), .smi_pulse(smi_pulse)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic [1:0] c);
      @(negedge clk);
      io_addr = a; io_wdata = d; cpu_idx = c; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, output logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      #1 d = io_rdata;
      io_rd = 1'b0;
   endtask

   task automatic fire(input logic [1:0] c, input logic [7:0] v, input string req);
      logic [3:0] exp;
      exp = bcast_m ? 4'hF : (4'b0001 << c);
      wr(16'h00B2, v, c);
      chk(req, {4'h0, smi_pulse}, {4'h0, exp});
      @(negedge clk);
      chk("R10", {4'h0, smi_pulse}, 8'h00);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      rd(16'h00B2, r); chk("R1", r, 8'h00);
      rd(16'h00B3, r); chk("R1", r, 8'h00);
      chk("R1", {4'h0, smi_pulse}, 8'h00);

      // Exhaustive status sweep, each followed by a command write
      for (int v = 0; v < 256; v++) begin
         logic [7:0] d, exp;
         logic bad;
         d = v[7:0];
         bad = |d[7:3];
         if (d[1]) exp = {6'b000001, 1'b0, d[0]};
         else      exp = {6'b000000, bad, d[0]};
         wr(16'h00B3, d, 2'(v));
         rd(16'h00B3, r);
         if (d[1])         chk("R3", r, exp);
         else if (bad)     chk("R5", r, exp);
         else              chk("R4", r, exp);
         chk("R2", {7'h0, r[0]}, {7'h0, d[0]});
         if (!d[1] && !bad) bcast_m = d[2];
         fire(2'(v >> 2), d, bcast_m ? "R9" : "R8");
         rd(16'h00B2, r); chk("R7", r, d);
      end

      // Clearing with 0x00 / 0x01 after broadcast enabled
      for (int k = 0; k < 2; k++) begin
         wr(16'h00B3, 8'h04, 2'd0); bcast_m = 1'b1;
         fire(2'd1, 8'h5A, "R9");
         wr(16'h00B3, 8'(k), 2'd0); bcast_m = 1'b0;
         rd(16'h00B3, r); chk("R6", r, 8'(k));
         fire(2'd3, 8'hA5, "R6");
      end

      // Invalid set keeps broadcast enabled
      wr(16'h00B3, 8'h04, 2'd0); bcast_m = 1'b1;
      wr(16'h00B3, 8'h0C, 2'd0);
      rd(16'h00B3, r); chk("R5", r, 8'h02);
      fire(2'd2, 8'h11, "R5");
      wr(16'h00B3, 8'h00, 2'd0); bcast_m = 1'b0;

      // Other addresses ignored
      wr(16'h00B2, 8'h3C, 2'd0);
      @(negedge clk);
      wr(16'h00B3, 8'h01, 2'd0);
      for (int a = 16'h00B0; a < 16'h00B6; a++) begin
         if (a == 16'h00B2 || a == 16'h00B3) continue;
         wr(16'(a), 8'hFF, 2'd1);
         chk("R11", {4'h0, smi_pulse}, 8'h00);
         rd(16'(a), r); chk("R11", r, 8'h00);
      end
      wr(16'h01B2, 8'hEE, 2'd2);
      chk("R11", {4'h0, smi_pulse}, 8'h00);
      rd(16'h00B2, r); chk("R11", r, 8'h3C);
      rd(16'h00B3, r); chk("R11", r, 8'h01);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule